// File: doc/BRIEF.md
# Triggered Double-Buffered Output Controller

This block owns a bank of output bits fed through two registers in series. The host first places the next pattern in a staging register. That pattern then moves into the live output register in one of two ways. One is a software command. The other is a chosen edge on an asynchronous trigger pin, which needs no help from the host. After a triggered transfer the block can raise an interrupt. The host uses it to load the pattern for the following step, so the timing of the outputs never depends on interrupt latency.

A small host port decodes four byte offsets. Offset 0 loads the staging register, and a read there returns the isolated input bits. Offset 1 commands the transfer, and a read there returns the live pattern. Offset 2 is the setup register. Offset 3 clears the pending interrupt. A word access at offset 0 loads the staging register and commands the transfer in the same cycle. The word's upper byte carries no information, so the port carries only the low byte plus a word flag.

Setup bits: bit 0 enables the interrupt, bit 1 enables the trigger, bit 2 sets the trigger polarity, and bit 3 lets both data registers survive a system reset. The power-on reset clears every register. The system reset input clears setup bits 2..0 and the pending flag, and it clears the data registers only when bit 3 is 0.

Top module: `dbuf_out_ctrl`

## Requirements
- R1: After power-on reset, outPins is 0x00, irqOut is 0, and reads at offsets 1 and 2 return 0x00.
- R2: A byte write at offset 0 loads the staging register and leaves outPins unchanged. A read at offset 0 returns isoIn in bits 3..0 and zeros above.
- R3: With setup bit 1 clear, a byte write at offset 1 copies the staging register to outPins, whatever its data. A read at offset 1 returns outPins.
- R4: With setup bit 1 clear, a write at offset 0 with wrWord=1 puts wrData into both the staging register and outPins in the same clock.
- R5: A byte write at offset 2 stores wrData[3:0]. A read at offset 2 returns those bits in 3..0, and bits 7..4 read as 0.
- R6: With setup bit 1 set, each edge of trigIn that matches bit 2 (1 = rising, 0 = falling) copies staging to outPins exactly once. The copy is visible after the third rising clock edge that follows the trigIn change. The opposite edge copies nothing.
- R7: With setup bit 1 set, a write at offset 1 and a word write at offset 0 leave outPins unchanged. The word write still loads the staging register.
- R8: With setup bit 0 set, a matching trigIn edge sets irqOut, even when bit 1 is clear and no copy takes place. irqOut holds until any write at offset 3.
- R9: When a matching edge and a write at offset 3 fall in the same cycle, irqOut stays 1.
- R10: When a triggered copy and a staging write fall in the same cycle, outPins takes the previous staged value and the new value stays staged.
- R11: A sysRst cycle clears setup bits 2..0 and irqOut and keeps setup bit 3. It clears the staging register and outPins only when setup bit 3 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Asynchronous power-on reset, active low, clears all state |
| sysRst | input | 1 | Synchronous system reset, active high |
| wrEn | input | 1 | Host write strobe for one cycle |
| wrWord | input | 1 | Marks the write as a 16-bit access |
| addr | input | 2 | Register offset for reads and writes |
| wrData | input | 8 | Write data (low byte of a word access) |
| isoIn | input | 4 | Isolated input levels, returned at offset 0 |
| trigIn | input | 1 | Asynchronous external trigger |
| rdData | output | 8 | Read data for the current offset |
| outPins | output | 8 | Live output pattern |
| irqOut | output | 1 | Pending interrupt |

## Verification
Two pairs of functions can land in the same clock cycle. The first is a qualified trigger edge and a clear write at offset 3. The second is a triggered copy and a staging load. The bench provokes each pair by counting the synchroniser delay: it changes trigIn and places the write two falling clock edges later. This makes the strobe land on the clock edge where the synchronised edge is seen. It then judges that irqOut stays set, and that outPins holds the old staged byte. A later triggered copy then releases the newly staged byte.

// File: rtl/dbuf_out_pkg.sv
package dbuf_out_pkg;

  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned SETUP_W = 4;

  localparam logic [ADDR_W-1:0] OFF_STAGE = 2'd0;
  localparam logic [ADDR_W-1:0] OFF_XFER  = 2'd1;
  localparam logic [ADDR_W-1:0] OFF_SETUP = 2'd2;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 2'd3;

  localparam int unsigned BIT_IRQ_EN  = 0;
  localparam int unsigned BIT_TRIG_EN = 1;
  localparam int unsigned BIT_POL     = 2;
  localparam int unsigned BIT_KEEP    = 3;

  typedef struct packed {
    logic loadStage;
    logic xfer;
    logic xferFromBus;
    logic clrData;
  } dbufStrobe_t;

endpackage

// File: rtl/dbuf_out_seq.sv
module dbuf_out_seq
  import dbuf_out_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               sysRst,
  input  logic               wrEn,
  input  logic               wrWord,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [SETUP_W-1:0] wrSetup,
  input  logic               trigIn,
  output logic [SETUP_W-1:0] setupQ,
  output logic               irqPend,
  output dbufStrobe_t        st
);

  localparam int unsigned SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic trigPrev;
  logic trigLvl, riseHit, fallHit, edgeHit;
  logic hitStage, hitXfer, hitSetup, clrHit, irqSet, swXfer;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      syncQ    <= '0;
      trigPrev <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_MSB-1:0], trigIn};
      trigPrev <= syncQ[SYNC_MSB];
    end
  end

  assign trigLvl = syncQ[SYNC_MSB];
  assign riseHit = trigLvl & ~trigPrev;
  assign fallHit = ~trigLvl & trigPrev;
  assign edgeHit = setupQ[BIT_POL] ? riseHit : fallHit;

  assign hitStage = wrEn && (addr == OFF_STAGE);
  assign hitXfer  = wrEn && (addr == OFF_XFER);
  assign hitSetup = wrEn && (addr == OFF_SETUP);
  assign clrHit   = wrEn && (addr == OFF_CLR);
  assign irqSet   = edgeHit && setupQ[BIT_IRQ_EN];
  assign swXfer   = !setupQ[BIT_TRIG_EN] && (hitXfer || (hitStage && wrWord));

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      setupQ <= '0;
    end else if (sysRst) begin
      setupQ[BIT_KEEP-1:0] <= '0;
    end else if (hitSetup) begin
      setupQ <= wrSetup;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      irqPend <= 1'b0;
    end else if (sysRst) begin
      irqPend <= 1'b0;
    end else if (irqSet) begin
      irqPend <= 1'b1;
    end else if (clrHit) begin
      irqPend <= 1'b0;
    end
  end

  always_comb begin
    st = '0;
    if (sysRst) begin
      st.clrData = !setupQ[BIT_KEEP];
    end else begin
      st.loadStage   = hitStage;
      st.xfer        = swXfer || (setupQ[BIT_TRIG_EN] && edgeHit);
      st.xferFromBus = swXfer && hitStage;
    end
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!porN)
    irqPend && !clrHit && !sysRst |=> irqPend); // R8

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!porN)
    irqSet && clrHit && !sysRst |=> irqPend); // R9

  AST_SW_BLOCKED: assert property (@(posedge clk) disable iff (!porN)
    setupQ[BIT_TRIG_EN] && !edgeHit |-> !st.xfer); // R7

  AST_KEEP_SURVIVES: assert property (@(posedge clk) disable iff (!porN)
    sysRst |=> setupQ[BIT_KEEP] == $past(setupQ[BIT_KEEP])); // R11

endmodule

// File: rtl/dbuf_out_regs.sv
module dbuf_out_regs
  import dbuf_out_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ISO_W  = 4
) (
  input  logic               clk,
  input  logic               porN,
  input  dbufStrobe_t        st,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ISO_W-1:0]   isoIn,
  input  logic [SETUP_W-1:0] setupQ,
  output logic [DATA_W-1:0]  outQ,
  output logic [DATA_W-1:0]  rdData
);

  localparam int unsigned ISO_PAD   = DATA_W - ISO_W;
  localparam int unsigned SETUP_PAD = DATA_W - SETUP_W;

  logic [DATA_W-1:0] stageQ;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      stageQ <= '0;
      outQ   <= '0;
    end else if (st.clrData) begin
      stageQ <= '0;
      outQ   <= '0;
    end else begin
      if (st.loadStage) begin
        stageQ <= wrData;
      end
      if (st.xfer) begin
        outQ <= st.xferFromBus ? wrData : stageQ;
      end
    end
  end

  always_comb begin
    unique case (addr)
      OFF_STAGE: rdData = {{ISO_PAD{1'b0}}, isoIn};
      OFF_XFER:  rdData = outQ;
      OFF_SETUP: rdData = {{SETUP_PAD{1'b0}}, setupQ};
      default:   rdData = '0;
    endcase
  end

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!porN)
    !st.xfer && !st.clrData |=> $stable(outQ)); // R2

  AST_CLEAR_DATA: assert property (@(posedge clk) disable iff (!porN)
    st.clrData |=> (outQ == '0) && (stageQ == '0)); // R11

  AST_SETUP_RSVD: assert property (@(posedge clk) disable iff (!porN)
    addr == OFF_SETUP |-> rdData[DATA_W-1:SETUP_W] == '0); // R5

endmodule

// File: rtl/dbuf_out_ctrl.sv
module dbuf_out_ctrl
  import dbuf_out_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ISO_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              sysRst,
  input  logic              wrEn,
  input  logic              wrWord,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ISO_W-1:0]  isoIn,
  input  logic              trigIn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] outPins,
  output logic              irqOut
);

  dbufStrobe_t        st;
  logic [SETUP_W-1:0] setupQ;

  dbuf_out_seq #(.SYNC_STAGES(SYNC_STAGES)) u_seq (
    .clk     (clk),
    .porN    (porN),
    .sysRst  (sysRst),
    .wrEn    (wrEn),
    .wrWord  (wrWord),
    .addr    (addr),
    .wrSetup (wrData[SETUP_W-1:0]),
    .trigIn  (trigIn),
    .setupQ  (setupQ),
    .irqPend (irqOut),
    .st      (st)
  );

  dbuf_out_regs #(.DATA_W(DATA_W), .ISO_W(ISO_W)) u_regs (
    .clk    (clk),
    .porN   (porN),
    .st     (st),
    .addr   (addr),
    .wrData (wrData),
    .isoIn  (isoIn),
    .setupQ (setupQ),
    .outQ   (outPins),
    .rdData (rdData)
  );

endmodule

// File: tb/dbuf_out_ctrl_tb.sv
`timescale 1ns/1ps
module dbuf_out_ctrl_tb;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } chkItem_t;

  logic clk = 1'b0;
  logic porN = 1'b0, sysRst = 1'b0, wrEn = 1'b0, wrWord = 1'b0, trigIn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [3:0] isoIn = 4'hA;
  logic [7:0] rdData, outPins;
  logic irqOut;

  int vectors = 0, fails = 0, pendingCnt = 0;
  bit done = 1'b0;
  chkItem_t q[$];
  event doCheck;

  always #2 clk = ~clk;

  dbuf_out_ctrl u_dut (
    .clk(clk), .porN(porN), .sysRst(sysRst), .wrEn(wrEn), .wrWord(wrWord),
    .addr(addr), .wrData(wrData), .isoIn(isoIn), .trigIn(trigIn),
    .rdData(rdData), .outPins(outPins), .irqOut(irqOut)
  );

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(doCheck);
      while (q.size() > 0) begin
        chkItem_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = rdData;
          1: act = outPins;
          default: act = {7'd0, irqOut};
        endcase
        vectors++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
        end
        pendingCnt--;
      end
    end
  end

  task automatic chk(input int kind, input logic [1:0] a, input logic [7:0] exp, input string tag);
    chkItem_t it;
    addr = a;
    #1;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    pendingCnt++;
    ->doCheck;
    wait (pendingCnt == 0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic w);
    @(negedge clk);
    addr = a; wrData = d; wrWord = w; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrWord = 1'b0;
  endtask

  task automatic trig(input logic v);
    @(negedge clk);
    trigIn = v;
    repeat (3) @(negedge clk);
  endtask

  // trigger change with a byte write landing on the cycle the edge is seen
  task automatic trigWithWrite(input logic v, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    trigIn = v;
    @(negedge clk);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseSysRst();
    @(negedge clk);
    sysRst = 1'b1;
    @(negedge clk);
    sysRst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(1, 2'd0, 8'h00, "R1 outPins after reset");
    chk(2, 2'd0, 8'h00, "R1 irqOut after reset");
    chk(0, 2'd1, 8'h00, "R1 output readback after reset");
    chk(0, 2'd2, 8'h00, "R1 setup readback after reset");
    chk(0, 2'd0, 8'h0A, "R2 isolated input read");

    // R2 staging write does not reach outputs
    wr(2'd0, 8'h5A, 1'b0);
    chk(1, 2'd0, 8'h00, "R2 outPins unchanged by staging write");
    chk(0, 2'd0, 8'h0A, "R2 offset0 read still isoIn");
    // R3 software transfer
    wr(2'd1, 8'hFF, 1'b0);
    chk(1, 2'd1, 8'h5A, "R3 transfer via offset1");
    chk(0, 2'd1, 8'h5A, "R3 output readback");
    // R4 word write
    wr(2'd0, 8'hC3, 1'b1);
    chk(1, 2'd1, 8'hC3, "R4 word write to outPins");
    // R5 setup readback
    wr(2'd2, 8'hFF, 1'b0);
    chk(0, 2'd2, 8'h0F, "R5 reserved setup bits read 0");
    wr(2'd2, 8'h06, 1'b0);
    chk(0, 2'd2, 8'h06, "R5 setup readback");
    // R7 software transfers blocked
    wr(2'd0, 8'h3C, 1'b0);
    wr(2'd1, 8'h00, 1'b0);
    chk(1, 2'd1, 8'hC3, "R7 offset1 write blocked");
    wr(2'd0, 8'h99, 1'b1);
    chk(1, 2'd1, 8'hC3, "R7 word write transfer blocked");
    // R6 rising edge transfers the word-loaded stage
    trig(1'b1);
    chk(1, 2'd1, 8'h99, "R6 rising edge transfer (R7 word staged)");
    chk(2, 2'd1, 8'h00, "R8 no irq when disabled");
    wr(2'd0, 8'h44, 1'b0);
    repeat (5) @(negedge clk);
    chk(1, 2'd1, 8'h99, "R6 single transfer per edge");
    trig(1'b0);
    chk(1, 2'd1, 8'h99, "R6 falling edge ignored in rising mode");
    // R8 falling polarity with interrupt
    wr(2'd2, 8'h03, 1'b0);
    trig(1'b1);
    chk(1, 2'd1, 8'h99, "R6 rising edge ignored in falling mode");
    chk(2, 2'd1, 8'h00, "R8 no irq on wrong edge");
    trig(1'b0);
    chk(1, 2'd1, 8'h44, "R6 falling edge transfer");
    chk(2, 2'd1, 8'h01, "R8 irq set on edge");
    wr(2'd0, 8'h11, 1'b0);
    repeat (4) @(negedge clk);
    chk(2, 2'd1, 8'h01, "R8 irq held");
    wr(2'd3, 8'h00, 1'b0);
    chk(2, 2'd1, 8'h00, "R8 irq cleared");
    // R8 interrupt-only mode
    wr(2'd2, 8'h01, 1'b0);
    trig(1'b1);
    trig(1'b0);
    chk(2, 2'd1, 8'h01, "R8 irq with trigger disabled");
    chk(1, 2'd1, 8'h44, "R8 no transfer with trigger disabled");
    wr(2'd3, 8'h00, 1'b0);
    // R9 edge and clear in same cycle
    trig(1'b1);
    chk(2, 2'd1, 8'h00, "R9 precondition irq clear");
    trigWithWrite(1'b0, 2'd3, 8'h00);
    chk(2, 2'd1, 8'h01, "R9 edge wins over clear");
    wr(2'd3, 8'h00, 1'b0);
    chk(2, 2'd1, 8'h00, "R9 later clear works");
    // R10 triggered copy with staging write
    wr(2'd2, 8'h06, 1'b0);
    trigWithWrite(1'b1, 2'd0, 8'h77);
    chk(1, 2'd1, 8'h11, "R10 copy takes previous stage");
    trig(1'b0);
    trig(1'b1);
    chk(1, 2'd1, 8'h77, "R10 new value stayed staged");
    // R11 keep bit set
    wr(2'd2, 8'h08, 1'b0);
    wr(2'd0, 8'h55, 1'b0);
    pulseSysRst();
    chk(1, 2'd1, 8'h77, "R11 outputs kept");
    chk(0, 2'd2, 8'h08, "R11 keep bit survives");
    wr(2'd1, 8'h00, 1'b0);
    chk(1, 2'd1, 8'h55, "R11 staging kept");
    // R11 keep bit clear
    wr(2'd2, 8'h07, 1'b0);
    wr(2'd0, 8'h66, 1'b0);
    trig(1'b0);
    trig(1'b1);
    chk(1, 2'd1, 8'h66, "R11 precondition transfer");
    chk(2, 2'd1, 8'h01, "R11 precondition irq");
    pulseSysRst();
    chk(1, 2'd1, 8'h00, "R11 outputs cleared");
    chk(2, 2'd1, 8'h00, "R11 irq cleared");
    chk(0, 2'd2, 8'h00, "R11 setup bits cleared");
    wr(2'd1, 8'h00, 1'b0);
    chk(1, 2'd1, 8'h00, "R11 staging cleared");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule